// File: doc/BRIEF.md
# Bridge Read Reorder Buffer

This block serves processor burst reads that target PCI space. A burst asks for a cache line of four 64-bit double words and names the word it needs first. The PCI side can only fetch in ascending order. So the block always starts the PCI fetch at the line-aligned address and stores each arriving word in a small line store. It then returns the whole line to the processor. Delivery starts at the requested word and wraps within the line.

The PCI target may end a transfer before the line is complete. When that happens, the block asks for the bus again and resumes at the first word it has not yet received. Another master may start a system-memory access while the block waits for a grant. In that case the block retries the processor so that the access can be snooped. The block keeps its partial line while the processor is off the bus. When the processor comes back, its request is compared with the latched address and attributes:

- A request that matches is served from the line store.
- A PCI read that does not match is retried until the held line has been delivered.
- Any other transaction is left alone.

The block acknowledges the processor and grants the data bus in one cycle. It does this only when three things hold: the line is complete, no snoop for a PCI write to memory is outstanding, and the processor data bus is free.

The controller has five states:

| State | Meaning |
|-------|---------|
| IDLE | Nothing is held. |
| FETCH_REQ | PCI bus requested, waiting for a grant. |
| FETCH_DATA | PCI data phases in progress. |
| HOLD | The line is complete and is waiting to be released. |
| BEAT | Four data beats go to the processor. |

The transitions are:

| From | To | When |
|------|----|------|
| IDLE | FETCH_REQ | A PCI read is accepted. |
| FETCH_REQ | FETCH_DATA | The grant arrives. |
| FETCH_DATA | HOLD | The fourth word is latched. |
| FETCH_DATA | FETCH_REQ | The target disconnects before the fourth word. |
| HOLD | BEAT | The release conditions are met. |
| BEAT | IDLE | The last beat has been delivered. |

Top module: `pci_read_reorder_buf`

## Requirements
- R1: The first PCI request for a line presents the line-aligned address (address bits 4:3 equal to zero), whatever word the processor asked for first.
- R2: After the acknowledge cycle, `cpu_dvalid` is high for four consecutive cycles. Beat k carries the word with index (critical + k) mod 4, where the critical index is `cpu_addr[4:3]`.
- R3: `cpu_aack` never rises while any of the four words is still missing.
- R4: After a disconnect that ends a transfer early, the next PCI request presents the address of the first word not yet received (line base + 8 × words received).
- R5: `pci_req` stays high from the acceptance of a read until the fourth word is latched. This holds even while the processor is retried and off the bus. `pci_req` drops in the cycle after the fourth word is latched.
- R6: In a cycle where the block waits for a grant, has an open processor tenure, sees `alt_mem_req` and has no grant, `cpu_retry` is high.
- R7: After a retry, a PCI read with the same address and attributes is taken back without a retry. The same address with different attributes is retried.
- R8: While a line is held, a PCI read to a different address is retried. A request with `cpu_pci_rd` low gets neither retry nor acknowledge.
- R9: `cpu_aack` stays low while `snoop_pend` is high.
- R10: `pci_wr_retry` is high while a complete line waits with `snoop_pend` high. It is low once the line is released.
- R11: `cpu_aack` and `cpu_dbg` rise together, and both stay low while `cpu_dbus_busy` is high.
- R12: After the fourth beat the block is idle: `cpu_dvalid` and `pci_req` are low and a new read is accepted.
- R13: After reset, every output strobe (`cpu_aack`, `cpu_dbg`, `cpu_retry`, `cpu_dvalid`, `pci_req`, `pci_wr_retry`) is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor address tenure present; held until acknowledge or retry |
| cpu_pci_rd | input | 1 | The tenure is a burst read to PCI space |
| cpu_addr | input | AW | Processor address; bits 4:3 select the critical word |
| cpu_attr | input | ATTR_W | Transaction attributes compared on re-presentation |
| cpu_dbus_busy | input | 1 | Processor data bus is in use |
| cpu_aack | output | 1 | Address acknowledge |
| cpu_dbg | output | 1 | Data bus grant |
| cpu_retry | output | 1 | Retry of the current processor tenure |
| cpu_dvalid | output | 1 | Data beat valid |
| cpu_data | output | DW | Data beat |
| pci_req | output | 1 | PCI bus request |
| pci_gnt | input | 1 | PCI bus grant |
| pci_addr | output | AW | Start address of the next PCI transfer |
| pci_dvalid | input | 1 | A PCI data phase completes this cycle |
| pci_data | input | DW | PCI read data |
| pci_disc | input | 1 | Target ends the transfer after this cycle |
| alt_mem_req | input | 1 | Another master starts a system-memory access |
| snoop_pend | input | 1 | A snoop for a PCI write to memory is outstanding |
| pci_wr_retry | output | 1 | Forces retry of new PCI writes to system memory |

## Verification
The bench builds the block with its default parameters: 64-bit words, four words per line, 32-bit addresses and 4-bit attributes. The 2-bit critical index then covers every possible starting word, including the wrap from word 3 back to word 0. A 3-bit disconnect mask reaches every way of splitting a line into one to four PCI transfers. The grant delay can be zero, so a grant can arrive in the first cycle of a fetch. With a nonzero grant delay, the window for an alternate-master retry opens. Varying snoop and busy lengths move the release point of a held line across several cycles.

// File: rtl/rrb_pkg.sv
`timescale 1ns/1ps
package rrb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_DATA,
        ST_HOLD,
        ST_BEAT
    } rrb_state_e;

endpackage

// File: rtl/rrb_line_store.sv
`timescale 1ns/1ps
// Line store: words are filled in ascending order and read at any index.
module rrb_line_store #(
    parameter int DW    = 64,
    parameter int WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic [$clog2(WORDS)-1:0]     rd_idx,
    output logic [DW-1:0]                rd_data,
    output logic [$clog2(WORDS):0]       fill,
    output logic [WORDS-1:0]             valid,
    output logic                         full
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int CNT_W = IDX_W + 1;

    logic [WORDS-1:0][DW-1:0] words_q;
    logic [WORDS-1:0]         vld_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [WORDS-1:0]         sel;

    // One-hot decode of the word slot that the next write fills.
    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_sel
            assign sel[i] = (cnt_q[IDX_W-1:0] == IDX_W'(i));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            vld_q <= '0;
            cnt_q <= '0;
        end else if (wr_en) begin
            vld_q <= vld_q | sel;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (wr_en && sel[i]) begin
                words_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = words_q[rd_idx];
    assign fill    = cnt_q;
    assign valid   = vld_q;
    assign full    = &vld_q;

    // R4: a resumed transfer never writes over a word that is already latched.
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

endmodule

// File: rtl/rrb_tenure_match.sv
`timescale 1ns/1ps
// Latches the accepted tenure and compares re-presented tenures against it.
module rrb_tenure_match #(
    parameter int AW     = 32,
    parameter int ATTR_W = 4,
    parameter int DW     = 64,
    parameter int WORDS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic [AW-1:0]            cpu_addr,
    input  logic [ATTR_W-1:0]        cpu_attr,
    output logic                     addr_match,
    output logic [AW-1:0]            line_base,
    output logic [$clog2(WORDS)-1:0] crit_idx
);
    localparam int OFS_W    = $clog2(DW / 8);
    localparam int IDX_W    = $clog2(WORDS);
    localparam int LINE_LSB = OFS_W + IDX_W;

    logic [AW-1:OFS_W]  addr_q;
    logic [ATTR_W-1:0]  attr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            attr_q <= '0;
        end else if (capture) begin
            addr_q <= cpu_addr[AW-1:OFS_W];
            attr_q <= cpu_attr;
        end
    end

    assign addr_match = (cpu_addr[AW-1:OFS_W] == addr_q) && (cpu_attr == attr_q);
    assign line_base  = {addr_q[AW-1:LINE_LSB], {LINE_LSB{1'b0}}};
    assign crit_idx   = addr_q[LINE_LSB-1:OFS_W];

endmodule

// File: rtl/rrb_ctrl.sv
`timescale 1ns/1ps
// Sequencer: fetch, resume, retry, release and beat delivery.
module rrb_ctrl
    import rrb_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_pci_rd,
    input  logic                     addr_match,
    input  logic                     cpu_dbus_busy,
    input  logic                     alt_mem_req,
    input  logic                     snoop_pend,
    input  logic                     pci_gnt,
    input  logic                     pci_dvalid,
    input  logic                     pci_disc,
    input  logic [$clog2(WORDS):0]   fill,
    output logic                     capture,
    output logic                     wr_en,
    output logic                     cpu_aack,
    output logic                     cpu_dbg,
    output logic                     cpu_retry,
    output logic                     cpu_dvalid,
    output logic                     pci_req,
    output logic                     pci_wr_retry,
    output logic [$clog2(WORDS)-1:0] beat
);
    localparam int                 IDX_W     = $clog2(WORDS);
    localparam int                 CNT_W     = IDX_W + 1;
    localparam logic [CNT_W-1:0]   LAST_FILL = CNT_W'(WORDS - 1);
    localparam logic [IDX_W-1:0]   LAST_BEAT = IDX_W'(WORDS - 1);

    rrb_state_e        state, state_n;
    logic              ten_open, ten_n;
    logic [IDX_W-1:0]  beat_q, beat_n;

    logic new_rd;
    logic alt_hit;
    logic last_word;
    logic launch;

    // A fresh PCI read from the processor while no tenure is held open.
    assign new_rd    = cpu_req && cpu_pci_rd && !ten_open;
    // Another master needs memory while the block still waits for the grant.
    assign alt_hit   = (state == ST_FETCH_REQ) && alt_mem_req && !pci_gnt;
    assign last_word = pci_dvalid && (fill == LAST_FILL);
    assign launch    = ten_open && !snoop_pend && !cpu_dbus_busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ten_open <= 1'b0;
            beat_q   <= '0;
        end else begin
            state    <= state_n;
            ten_open <= ten_n;
            beat_q   <= beat_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        ten_n   = ten_open;
        beat_n  = beat_q;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req && cpu_pci_rd) begin
                    state_n = ST_FETCH_REQ;
                    ten_n   = 1'b1;
                end
            end
            ST_FETCH_REQ: begin
                if (pci_gnt) begin
                    state_n = ST_FETCH_DATA;
                end
                if (ten_open && cpu_req && alt_hit) begin
                    ten_n = 1'b0;
                end else if (new_rd && addr_match && !alt_hit) begin
                    ten_n = 1'b1;
                end
            end
            ST_FETCH_DATA: begin
                if (last_word) begin
                    state_n = ST_HOLD;
                end else if (pci_disc) begin
                    state_n = ST_FETCH_REQ;
                end
                if (new_rd && addr_match) begin
                    ten_n = 1'b1;
                end
            end
            ST_HOLD: begin
                if (launch) begin
                    state_n = ST_BEAT;
                    ten_n   = 1'b0;
                    beat_n  = '0;
                end else if (new_rd && addr_match) begin
                    ten_n = 1'b1;
                end
            end
            ST_BEAT: begin
                beat_n = beat_q + IDX_W'(1);
                if (beat_q == LAST_BEAT) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        capture      = 1'b0;
        wr_en        = 1'b0;
        cpu_aack     = 1'b0;
        cpu_dbg      = 1'b0;
        cpu_retry    = 1'b0;
        cpu_dvalid   = 1'b0;
        pci_req      = 1'b0;
        pci_wr_retry = 1'b0;
        unique case (state)
            ST_IDLE: begin
                capture = cpu_req && cpu_pci_rd;
            end
            ST_FETCH_REQ: begin
                pci_req   = 1'b1;
                cpu_retry = (ten_open && cpu_req && alt_hit) ||
                            (new_rd && (!addr_match || alt_hit));
            end
            ST_FETCH_DATA: begin
                pci_req   = 1'b1;
                wr_en     = pci_dvalid;
                cpu_retry = new_rd && !addr_match;
            end
            ST_HOLD: begin
                cpu_aack     = launch;
                cpu_dbg      = launch;
                pci_wr_retry = snoop_pend;
                cpu_retry    = new_rd && !addr_match;
            end
            ST_BEAT: begin
                cpu_dvalid = 1'b1;
                cpu_retry  = cpu_req && cpu_pci_rd;
            end
            default: ;
        endcase
    end

    assign beat = beat_q;

    // R6: a tenure that is retried is never acknowledged in the same cycle.
    a_r6_retry_no_aack: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_retry |-> !cpu_aack);

    // R12: delivery of a line always ends with a return to idle.
    a_r12_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_dvalid) |-> (state == ST_IDLE));

endmodule

// File: rtl/pci_read_reorder_buf.sv
`timescale 1ns/1ps
module pci_read_reorder_buf #(
    parameter int AW     = 32,
    parameter int DW     = 64,
    parameter int ATTR_W = 4,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_pci_rd,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [ATTR_W-1:0] cpu_attr,
    input  logic              cpu_dbus_busy,
    output logic              cpu_aack,
    output logic              cpu_dbg,
    output logic              cpu_retry,
    output logic              cpu_dvalid,
    output logic [DW-1:0]     cpu_data,
    output logic              pci_req,
    input  logic              pci_gnt,
    output logic [AW-1:0]     pci_addr,
    input  logic              pci_dvalid,
    input  logic [DW-1:0]     pci_data,
    input  logic              pci_disc,
    input  logic              alt_mem_req,
    input  logic              snoop_pend,
    output logic              pci_wr_retry
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int CNT_W = IDX_W + 1;
    localparam int OFS_W = $clog2(DW / 8);

    logic              capture;
    logic              wr_en;
    logic              addr_match;
    logic [AW-1:0]     line_base;
    logic [IDX_W-1:0]  crit_idx;
    logic [IDX_W-1:0]  beat;
    logic [IDX_W-1:0]  rd_idx;
    logic [CNT_W-1:0]  fill;
    logic [WORDS-1:0]  valid;
    logic              full;

    rrb_tenure_match #(
        .AW(AW), .ATTR_W(ATTR_W), .DW(DW), .WORDS(WORDS)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .cpu_addr   (cpu_addr),
        .cpu_attr   (cpu_attr),
        .addr_match (addr_match),
        .line_base  (line_base),
        .crit_idx   (crit_idx)
    );

    rrb_line_store #(
        .DW(DW), .WORDS(WORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (capture),
        .wr_en   (wr_en),
        .wr_data (pci_data),
        .rd_idx  (rd_idx),
        .rd_data (cpu_data),
        .fill    (fill),
        .valid   (valid),
        .full    (full)
    );

    rrb_ctrl #(
        .WORDS(WORDS)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req       (cpu_req),
        .cpu_pci_rd    (cpu_pci_rd),
        .addr_match    (addr_match),
        .cpu_dbus_busy (cpu_dbus_busy),
        .alt_mem_req   (alt_mem_req),
        .snoop_pend    (snoop_pend),
        .pci_gnt       (pci_gnt),
        .pci_dvalid    (pci_dvalid),
        .pci_disc      (pci_disc),
        .fill          (fill),
        .capture       (capture),
        .wr_en         (wr_en),
        .cpu_aack      (cpu_aack),
        .cpu_dbg       (cpu_dbg),
        .cpu_retry     (cpu_retry),
        .cpu_dvalid    (cpu_dvalid),
        .pci_req       (pci_req),
        .pci_wr_retry  (pci_wr_retry),
        .beat          (beat)
    );

    // Critical-word-first delivery: the index wraps within the line.
    assign rd_idx   = crit_idx + beat;
    // Resume point: line base plus the count of words already latched.
    assign pci_addr = line_base | (AW'(fill[IDX_W-1:0]) << OFS_W);

    // R3: acknowledge only with every word of the line latched.
    a_r3_aack_full: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_aack |-> ($countones(valid) == WORDS));

    // R2: data beats start in the cycle after the acknowledge.
    a_r2_beat_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_aack |=> cpu_dvalid);

    // R5: the PCI request is only withdrawn once the line is complete.
    a_r5_req_until_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_req) |-> full);

endmodule

// File: tb/pci_read_reorder_buf_tb.sv
`timescale 1ns/1ps
module pci_read_reorder_buf_tb;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int AT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_pci_rd = 1'b0, cpu_dbus_busy = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [AT-1:0] cpu_attr = '0;
    logic          cpu_aack, cpu_dbg, cpu_retry, cpu_dvalid, pci_req, pci_wr_retry;
    logic [DW-1:0] cpu_data;
    logic          pci_gnt = 1'b0, pci_dvalid = 1'b0, pci_disc = 1'b0;
    logic          alt_mem_req = 1'b0, snoop_pend = 1'b0;
    logic [DW-1:0] pci_data = '0;
    logic [AW-1:0] pci_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pci_read_reorder_buf u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_pci_rd(cpu_pci_rd),
        .cpu_addr(cpu_addr), .cpu_attr(cpu_attr), .cpu_dbus_busy(cpu_dbus_busy),
        .cpu_aack(cpu_aack), .cpu_dbg(cpu_dbg), .cpu_retry(cpu_retry),
        .cpu_dvalid(cpu_dvalid), .cpu_data(cpu_data), .pci_req(pci_req),
        .pci_gnt(pci_gnt), .pci_addr(pci_addr), .pci_dvalid(pci_dvalid),
        .pci_data(pci_data), .pci_disc(pci_disc), .alt_mem_req(alt_mem_req),
        .snoop_pend(snoop_pend), .pci_wr_retry(pci_wr_retry)
    );

    function automatic logic [DW-1:0] line_word(input logic [31:0] tag, input int idx);
        return {tag, 32'(idx) ^ 32'h5A5A_0000};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One processor read of a line, with optional disconnects, alternate-master
    // retry, snoop wait and busy data bus.
    task automatic run_txn(input logic [31:0] addr, input logic [AT-1:0] attr,
                           input logic [2:0] disc_mask, input int gdelay,
                           input bit do_alt, input int snoop_n, input int busy_n,
                           input logic [31:0] tag);
        logic [31:0] base;
        int          crit;
        int          fill;
        bit          disc;
        bit          alt_left;
        base     = addr & 32'hFFFF_FFE0;
        crit     = int'(addr[4:3]);
        alt_left = do_alt;
        cpu_req = 1'b1; cpu_pci_rd = 1'b1; cpu_addr = addr; cpu_attr = attr;
        #1;
        chk("R8 accept without retry", 64'(cpu_retry), 64'd0);
        tick();
        fill = 0;
        while (fill < 4) begin
            #1;
            chk("R5 request held", 64'(pci_req), 64'd1);
            if (fill == 0) chk("R1 line-aligned start", 64'(pci_addr), 64'(base));
            else           chk("R4 resume address", 64'(pci_addr), 64'(base + 32'(fill * 8)));
            for (int g = 0; g < gdelay; g++) begin
                if (alt_left) begin
                    alt_left = 1'b0;
                    alt_mem_req = 1'b1;
                    #1;
                    chk("R6 retry on alternate master", 64'(cpu_retry), 64'd1);
                    tick();
                    alt_mem_req = 1'b0; cpu_req = 1'b0;
                    #1;
                    chk("R5 request kept while processor away", 64'(pci_req), 64'd1);
                    tick();
                    cpu_req = 1'b1; cpu_addr = addr ^ 32'h0000_1000;
                    #1;
                    chk("R8 mismatching read retried", 64'(cpu_retry), 64'd1);
                    tick();
                    cpu_req = 1'b0;
                    tick();
                    cpu_req = 1'b1; cpu_pci_rd = 1'b0;
                    #1;
                    chk("R8 non-read no retry", 64'(cpu_retry), 64'd0);
                    chk("R8 non-read no aack", 64'(cpu_aack), 64'd0);
                    tick();
                    cpu_pci_rd = 1'b1; cpu_addr = addr; cpu_attr = attr ^ 4'h1;
                    #1;
                    chk("R7 attribute mismatch retried", 64'(cpu_retry), 64'd1);
                    tick();
                    cpu_req = 1'b0;
                    tick();
                    cpu_req = 1'b1; cpu_attr = attr;
                    #1;
                    chk("R7 match taken back", 64'(cpu_retry), 64'd0);
                end
                tick();
            end
            pci_gnt = 1'b1;
            tick();
            pci_gnt = 1'b0;
            do begin
                disc = disc_mask[fill % 3] && (fill < 3);
                pci_dvalid = 1'b1; pci_data = line_word(tag, fill); pci_disc = disc;
                #1;
                chk("R3 no aack before line complete", 64'(cpu_aack), 64'd0);
                tick();
                fill++;
            end while (!disc && fill < 4);
            pci_dvalid = 1'b0; pci_disc = 1'b0;
        end
        #1;
        chk("R5 request dropped after line", 64'(pci_req), 64'd0);
        for (int s = 0; s < snoop_n; s++) begin
            snoop_pend = 1'b1;
            #1;
            chk("R9 aack blocked by snoop", 64'(cpu_aack), 64'd0);
            chk("R10 write retry while waiting", 64'(pci_wr_retry), 64'd1);
            tick();
        end
        snoop_pend = 1'b0;
        for (int b = 0; b < busy_n; b++) begin
            cpu_dbus_busy = 1'b1;
            #1;
            chk("R11 aack blocked by busy bus", 64'(cpu_aack), 64'd0);
            chk("R11 dbg blocked by busy bus", 64'(cpu_dbg), 64'd0);
            tick();
        end
        cpu_dbus_busy = 1'b0;
        #1;
        chk("R11 aack on release", 64'(cpu_aack), 64'd1);
        chk("R11 dbg with aack", 64'(cpu_dbg), 64'd1);
        chk("R10 write retry off", 64'(pci_wr_retry), 64'd0);
        tick();
        cpu_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R2 beat valid", 64'(cpu_dvalid), 64'd1);
            chk("R2 critical-first data", cpu_data, line_word(tag, (crit + k) % 4));
            tick();
        end
        #1;
        chk("R12 idle after fourth beat", 64'(cpu_dvalid), 64'd0);
        chk("R12 no request when idle", 64'(pci_req), 64'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R13 reset aack", 64'(cpu_aack), 64'd0);
        chk("R13 reset retry", 64'(cpu_retry), 64'd0);
        chk("R13 reset dvalid", 64'(cpu_dvalid), 64'd0);
        chk("R13 reset pci_req", 64'(pci_req), 64'd0);
        chk("R13 reset write retry", 64'(pci_wr_retry), 64'd0);
        chk("R13 reset dbg", 64'(cpu_dbg), 64'd0);
        rst_n = 1'b1;
        tick();
        // Directed corners
        run_txn(32'h1000_0000, 4'h3, 3'b000, 0, 1'b0, 0, 0, 32'hC0DE_0001);
        run_txn(32'h2000_0018, 4'h5, 3'b111, 1, 1'b0, 1, 1, 32'hC0DE_0002);
        run_txn(32'h3000_0048, 4'h9, 3'b010, 2, 1'b1, 2, 0, 32'hC0DE_0003);
        run_txn(32'h4000_0070, 4'hA, 3'b001, 1, 1'b1, 0, 2, 32'hC0DE_0004);
        // Random
        for (int t = 0; t < 40; t++) begin
            logic [31:0] a;
            bit          alt;
            int          gd;
            a   = $urandom() & 32'hFFFF_FFF8;
            alt = ($urandom() % 3) == 0;
            gd  = int'($urandom() % 3);
            if (alt && gd == 0) gd = 1;
            run_txn(a, 4'($urandom()), 3'($urandom()), gd, alt,
                    int'($urandom() % 3), int'($urandom() % 3), $urandom());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule